// File: doc/BRIEF.md
# Outstanding Memory Operation Wait Counters

This block keeps, for one wavefront, a running count of memory instructions that have been issued and have not yet finished. There are two counters. The vector counter covers vector loads and vector stores. The shared counter covers shared-memory operations and scalar memory operations. An issue strobe carries an operation class and adds one to the matching counter. Completion strobes take counts away again. The completion point depends on the class:

- A vector load is finished once its data has been written into the destination registers.
- A vector store is finished once the second-level cache accepts it. This is earlier than global visibility.
- A shared-memory operation is finished when it completes inside the shared memory.

A wait request carries one threshold per counter. The wavefront is stalled until both counters are at or below their thresholds. Vector operations from one wavefront retire in issue order, so a vector threshold of N means that all but the N youngest vector operations are done. For example, five issued with a threshold of three releases once two have finished. The two classes are tracked independently, and no ordering is assumed between them. The memory system itself is outside the block and drives the completion strobes.

Top module: `memop_wait_tracker`

## Requirements
- R1: After a synchronous active-high reset both counters read 0, `stall` is low and `issue_ready` is high.
- R2: An accepted issue with `issue_class` 0 (vector load) or 1 (vector store) raises `vec_count` by one in the next cycle. An accepted issue with class 2 (shared memory) or 3 (scalar memory) raises `shr_count` by one in the next cycle.
- R3: `vload_wb` (load data written to registers) and `vstore_ack` (store accepted by the second-level cache) each lower `vec_count` by one. When both are high in the same cycle, `vec_count` drops by two.
- R4: `shared_done` and `scalar_done` each lower `shr_count` by one. When both are high in the same cycle, `shr_count` drops by two.
- R5: An accepted issue and a single completion on the same counter in the same cycle leave that counter unchanged.
- R6: Issues and completions on one counter never change the other counter.
- R7: Both counters are CNT_W bits wide (6 by default) and saturate at 2^CNT_W-1 (63). While the counter chosen by `issue_class` is at that maximum, `issue_ready` is low, an issue is refused, and the counter stays at the maximum.
- R8: A completion strobe on a counter that is already 0 is ignored, and the counter stays at 0.
- R9: `stall` goes high in the same cycle as `wait_req` if `vec_count` is above `wait_vec_thr` or `shr_count` is above `wait_shr_thr`. It then stays high, using the thresholds captured with the request, until a cycle in which both counts are at or below those thresholds. `stall` is low in that cycle.
- R10: A threshold equal to the counter maximum (63) means that counter is not waited on.
- R11: A wait request whose thresholds are already met never raises `stall`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| issue_valid | input | 1 | Memory instruction issue strobe |
| issue_class | input | 2 | 0 vector load, 1 vector store, 2 shared memory, 3 scalar memory |
| issue_ready | output | 1 | Low when the counter for `issue_class` is saturated |
| vload_wb | input | 1 | A vector load has written its destination registers |
| vstore_ack | input | 1 | A vector store has reached the second-level cache |
| shared_done | input | 1 | A shared-memory operation has completed |
| scalar_done | input | 1 | A scalar memory operation has completed |
| wait_req | input | 1 | Wait instruction strobe |
| wait_vec_thr | input | CNT_W | Vector counter threshold |
| wait_shr_thr | input | CNT_W | Shared counter threshold |
| stall | output | 1 | Wavefront must hold |
| vec_count | output | CNT_W | Outstanding vector operations |
| shr_count | output | CNT_W | Outstanding shared and scalar operations |

## Verification
The counters are registered, so the effect of an issue or a completion shows on `vec_count` and `shr_count` one cycle after the strobe. `stall` and `issue_ready` are combinational, so they are due in the same cycle as the request or class that drives them, and are computed from the counts already held in that cycle. The bench drives each cycle's inputs on the falling edge and queues the expected values of that cycle. A monitor compares them shortly before the next rising edge, which lines every check up with the counts that the previous cycles produced.

// File: rtl/memop_wait_pkg.sv
package memop_wait_pkg;

    localparam int CNT_W   = 6;
    localparam int NUM_CNT = 2;
    localparam int VEC_IDX = 0;
    localparam int SHR_IDX = 1;

    typedef enum logic [1:0] {
        OP_VLOAD  = 2'd0,
        OP_VSTORE = 2'd1,
        OP_SHARED = 2'd2,
        OP_SCALAR = 2'd3
    } op_class_e;

    typedef struct packed {
        logic       inc;
        logic [1:0] dec;
    } cnt_ctrl_t;

    function automatic logic is_vector(op_class_e c);
        return (c == OP_VLOAD) || (c == OP_VSTORE);
    endfunction

    function automatic logic [1:0] pair_sum(logic a, logic b);
        return {1'b0, a} + {1'b0, b};
    endfunction

endpackage

// File: rtl/memop_counter.sv
module memop_counter
    import memop_wait_pkg::*;
#(
    parameter int W = CNT_W
) (
    input  logic         clk,
    input  logic         rst,
    input  cnt_ctrl_t    ctrl,
    output logic [W-1:0] count,
    output logic         room
);
    localparam logic [W-1:0] MAXV = {W{1'b1}};
    localparam int           SW   = W + 2;

    logic [SW-1:0] raised;
    logic [SW-1:0] dec_w;
    logic [W-1:0]  nxt;

    always_comb begin
        raised = {2'b00, count} + {{(SW-1){1'b0}}, ctrl.inc};
        dec_w  = {{(SW-2){1'b0}}, ctrl.dec};
        if (raised < dec_w)
            nxt = '0;
        else
            nxt = W'(raised - dec_w);
    end

    always_ff @(posedge clk) begin
        if (rst) count <= '0;
        else     count <= nxt;
    end

    assign room = (count != MAXV);

    p_reset_clear_r1: assert property (@(posedge clk) rst |=> (count == '0))
        else $error("counter not cleared by reset");
    p_no_overflow_r7: assert property (@(posedge clk) disable iff (rst)
        (count == MAXV && ctrl.dec == 2'd0) |=> (count == MAXV))
        else $error("saturated counter moved");
    p_floor_r8: assert property (@(posedge clk) disable iff (rst)
        (count == '0 && !ctrl.inc) |=> (count == '0))
        else $error("counter went below zero");
    p_balance_r5: assert property (@(posedge clk) disable iff (rst)
        (ctrl.inc && ctrl.dec == 2'd1) |=> $stable(count))
        else $error("issue plus completion changed counter");
endmodule

// File: rtl/memop_wait_gate.sv
module memop_wait_gate
    import memop_wait_pkg::*;
#(
    parameter int W = CNT_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         req,
    input  logic [W-1:0] req_vec_thr,
    input  logic [W-1:0] req_shr_thr,
    input  logic [W-1:0] vcnt,
    input  logic [W-1:0] scnt,
    output logic         stall
);
    logic         held;
    logic [W-1:0] held_vec_thr;
    logic [W-1:0] held_shr_thr;
    logic [W-1:0] eff_vec_thr;
    logic [W-1:0] eff_shr_thr;
    logic         met;

    always_comb begin
        eff_vec_thr = req ? req_vec_thr : held_vec_thr;
        eff_shr_thr = req ? req_shr_thr : held_shr_thr;
        met         = (vcnt <= eff_vec_thr) && (scnt <= eff_shr_thr);
        stall       = (req || held) && !met;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            held         <= 1'b0;
            held_vec_thr <= '0;
            held_shr_thr <= '0;
        end else begin
            held <= stall;
            if (req) begin
                held_vec_thr <= req_vec_thr;
                held_shr_thr <= req_shr_thr;
            end
        end
    end

    p_idle_no_stall_r11: assert property (@(posedge clk) disable iff (rst)
        (!req && !held) |-> !stall)
        else $error("stall without a wait");
    p_stall_needs_work_r9: assert property (@(posedge clk) disable iff (rst)
        stall |-> (vcnt != '0 || scnt != '0))
        else $error("stall with nothing outstanding");
endmodule

// File: rtl/memop_wait_tracker.sv
module memop_wait_tracker
    import memop_wait_pkg::*;
#(
    parameter int CNT_W = memop_wait_pkg::CNT_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             issue_valid,
    input  logic [1:0]       issue_class,
    output logic             issue_ready,
    input  logic             vload_wb,
    input  logic             vstore_ack,
    input  logic             shared_done,
    input  logic             scalar_done,
    input  logic             wait_req,
    input  logic [CNT_W-1:0] wait_vec_thr,
    input  logic [CNT_W-1:0] wait_shr_thr,
    output logic             stall,
    output logic [CNT_W-1:0] vec_count,
    output logic [CNT_W-1:0] shr_count
);
    op_class_e        cls;
    logic             sel_vec;
    logic             accept;
    cnt_ctrl_t        ctrl  [NUM_CNT];
    logic [CNT_W-1:0] cnt   [NUM_CNT];
    logic             room  [NUM_CNT];

    always_comb begin
        cls         = op_class_e'(issue_class);
        sel_vec     = is_vector(cls);
        issue_ready = sel_vec ? room[VEC_IDX] : room[SHR_IDX];
        accept      = issue_valid && issue_ready;
        ctrl[VEC_IDX].inc = accept && sel_vec;
        ctrl[VEC_IDX].dec = pair_sum(vload_wb, vstore_ack);
        ctrl[SHR_IDX].inc = accept && !sel_vec;
        ctrl[SHR_IDX].dec = pair_sum(shared_done, scalar_done);
    end

    for (genvar g = 0; g < NUM_CNT; g++) begin : g_cnt
        memop_counter #(.W(CNT_W)) u_cnt (
            .clk   (clk),
            .rst   (rst),
            .ctrl  (ctrl[g]),
            .count (cnt[g]),
            .room  (room[g])
        );
    end

    assign vec_count = cnt[VEC_IDX];
    assign shr_count = cnt[SHR_IDX];

    memop_wait_gate #(.W(CNT_W)) u_gate (
        .clk         (clk),
        .rst         (rst),
        .req         (wait_req),
        .req_vec_thr (wait_vec_thr),
        .req_shr_thr (wait_shr_thr),
        .vcnt        (vec_count),
        .scnt        (shr_count),
        .stall       (stall)
    );

    p_shr_isolated_r6: assert property (@(posedge clk) disable iff (rst)
        (!(issue_valid && !is_vector(op_class_e'(issue_class))) && !shared_done && !scalar_done)
        |=> $stable(shr_count))
        else $error("shared counter moved by vector traffic");
    p_vec_isolated_r6: assert property (@(posedge clk) disable iff (rst)
        (!(issue_valid && is_vector(op_class_e'(issue_class))) && !vload_wb && !vstore_ack)
        |=> $stable(vec_count))
        else $error("vector counter moved by other traffic");
    p_vec_step_r2: assert property (@(posedge clk) disable iff (rst)
        (issue_valid && issue_ready && is_vector(op_class_e'(issue_class)) && !vload_wb && !vstore_ack)
        |=> (vec_count == $past(vec_count) + 1'b1))
        else $error("vector issue not counted");
endmodule

// File: tb/memop_wait_tracker_tb.sv
`timescale 1ns/1ps
module memop_wait_tracker_tb;
    localparam int W    = 6;
    localparam int MAXV = 63;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic issue_valid = 0;
    logic [1:0] issue_class = 0;
    logic issue_ready;
    logic vload_wb = 0, vstore_ack = 0, shared_done = 0, scalar_done = 0;
    logic wait_req = 0;
    logic [W-1:0] wait_vec_thr = 0, wait_shr_thr = 0;
    logic stall;
    logic [W-1:0] vec_count, shr_count;

    always #2.5 clk = ~clk;

    memop_wait_tracker #(.CNT_W(W)) u_dut (
        .clk(clk), .rst(rst), .issue_valid(issue_valid), .issue_class(issue_class),
        .issue_ready(issue_ready), .vload_wb(vload_wb), .vstore_ack(vstore_ack),
        .shared_done(shared_done), .scalar_done(scalar_done), .wait_req(wait_req),
        .wait_vec_thr(wait_vec_thr), .wait_shr_thr(wait_shr_thr), .stall(stall),
        .vec_count(vec_count), .shr_count(shr_count)
    );

    typedef struct {
        string tag;
        int    vec;
        int    shr;
        bit    stl;
        bit    rdy;
    } exp_t;

    exp_t q[$];
    int checks = 0, errors = 0;
    bit done = 0;

    // requirement model
    int m_vec = 0, m_shr = 0;
    bit m_held = 0;
    int m_hv = 0, m_hs = 0;

    task automatic go(input string tag);
        exp_t e;
        bit vecsel, rdy, acc, stl;
        int vt, st, nv, ns;
        vecsel = (issue_class < 2);
        rdy = vecsel ? (m_vec < MAXV) : (m_shr < MAXV);
        acc = issue_valid && rdy;
        vt = wait_req ? int'(wait_vec_thr) : m_hv;
        st = wait_req ? int'(wait_shr_thr) : m_hs;
        stl = (wait_req || m_held) && !(m_vec <= vt && m_shr <= st);
        e.tag = tag; e.vec = m_vec; e.shr = m_shr; e.stl = stl; e.rdy = rdy;
        q.push_back(e);
        nv = m_vec + int'(acc && vecsel) - int'(vload_wb) - int'(vstore_ack);
        ns = m_shr + int'(acc && !vecsel) - int'(shared_done) - int'(scalar_done);
        m_vec = (nv < 0) ? 0 : nv;
        m_shr = (ns < 0) ? 0 : ns;
        m_held = stl;
        if (wait_req) begin m_hv = int'(wait_vec_thr); m_hs = int'(wait_shr_thr); end
        @(negedge clk);
        issue_valid = 0; vload_wb = 0; vstore_ack = 0; shared_done = 0;
        scalar_done = 0; wait_req = 0;
    endtask

    task automatic issue(input int c, input string tag);
        issue_valid = 1; issue_class = 2'(c);
        go(tag);
    endtask

    // monitor
    initial begin
        forever begin
            @(negedge clk);
            #2;
            while (q.size() > 0) begin
                exp_t e;
                e = q.pop_front();
                checks++;
                if (int'(vec_count) != e.vec || int'(shr_count) != e.shr ||
                    stall != e.stl || issue_ready != e.rdy) begin
                    errors++;
                    $display("FAIL %s: vec=%0d shr=%0d stall=%0b ready=%0b expected vec=%0d shr=%0d stall=%0b ready=%0b",
                             e.tag, vec_count, shr_count, stall, issue_ready,
                             e.vec, e.shr, e.stl, e.rdy);
                end
            end
        end
    end

    initial begin
        #(200000 * 5);
        if (!done) begin
            done = 1;
            errors++; checks++;
            $display("FAIL watchdog: run did not end, expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        @(negedge clk); @(negedge clk); @(negedge clk);
        rst = 0;
        go("R1 reset state");
        // R2 issue per class
        issue(0, "R2 vector load issue");
        issue(1, "R2 vector store issue");
        issue(2, "R2 shared issue");
        issue(3, "R2 scalar issue");
        go("R2 R6 counts after issues");
        // R3 vector completions
        vload_wb = 1; go("R3 load writeback");
        vstore_ack = 1; go("R3 store ack");
        issue(0, "R3 refill a");
        issue(1, "R3 refill b");
        vload_wb = 1; vstore_ack = 1; go("R3 both vector completions");
        // R4 shared completions
        shared_done = 1; go("R4 shared done");
        issue(2, "R4 refill a");
        issue(3, "R4 refill b");
        shared_done = 1; scalar_done = 1; go("R4 both shared completions");
        // R5 same-cycle balance
        issue(0, "R5 prime vec");
        issue(2, "R5 prime shr");
        issue_valid = 1; issue_class = 0; vload_wb = 1; go("R5 vector issue with completion");
        issue_valid = 1; issue_class = 2; shared_done = 1; go("R5 shared issue with completion");
        go("R5 R6 counts unchanged");
        // drain
        vload_wb = 1; shared_done = 1; go("R6 drain both");
        // R8 completions at zero
        vload_wb = 1; vstore_ack = 1; scalar_done = 1; shared_done = 1; go("R8 completion at zero");
        go("R8 counters still zero");
        // R9 five issued, threshold three
        for (int i = 0; i < 5; i++) issue(0, "R9 issue vector");
        issue(3, "R9 issue scalar");
        wait_req = 1; wait_vec_thr = 3; wait_shr_thr = MAXV; go("R9 wait vec thr 3 raises stall");
        go("R9 stall held");
        vload_wb = 1; go("R9 first completion, still stalled");
        vload_wb = 1; go("R9 second completion");
        go("R9 stall released at 3");
        go("R9 stays released");
        // R10 max threshold ignores counter
        wait_req = 1; wait_vec_thr = MAXV; wait_shr_thr = MAXV; go("R10 both thresholds max");
        wait_req = 1; wait_vec_thr = MAXV; wait_shr_thr = 0; go("R10 shared waited, vector ignored");
        scalar_done = 1; go("R10 scalar completion");
        go("R10 release on shared zero");
        // R11 already met
        wait_req = 1; wait_vec_thr = 3; wait_shr_thr = 0; go("R11 met wait no stall");
        go("R11 no held stall");
        // R7 saturation
        for (int i = 0; i < MAXV; i++) issue(1, "R7 fill vector");
        issue(0, "R7 refused at max");
        issue(1, "R7 still refused");
        issue(2, "R7 shared still ready");
        wait_req = 1; wait_vec_thr = MAXV; wait_shr_thr = MAXV; go("R10 max threshold at max count");
        vstore_ack = 1; go("R7 room after completion");
        issue(0, "R7 accepted again");
        go("R7 back at max");
        @(negedge clk); @(negedge clk);
        if (!done) begin
            done = 1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule